// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a small 8-bit accumulator processor. On every falling clock edge it captures the current instruction byte and the carry and zero flags into a microcode address register, and it advances a 3-bit microstep counter. The captured opcode, flags and step address a built-in microcode table. Its control word drives the datapath strobes, which the rest of the machine samples on the rising edge. All control changes therefore happen half a cycle away from the edge where the datapath acts.

Which unit drives the shared bus is not held in separate control bits. It comes from one 3-bit select field, so two drivers can never be enabled together. Instructions have variable length, because the microcode can request a synchronous clear of the step counter. The table covers a no-op, an accumulator load from memory, a load-immediate into any of eight register slots, a subroutine call and a return. Every other opcode runs the fetch and then ends. An external disable input forces every strobe inactive. This lets another agent take over the bus while the sequencer keeps counting.

Top module: `ucode_seq`

## Requirements
- R1: The 3-bit driver field decodes as follows: code 1 gives bus_oe[0] (RAM), 2 gives bus_oe[1] (instruction register low bits), 3 gives bus_oe[2] (program counter), 4 gives bus_oe[3] (accumulator), 5 gives bus_oe[4] (ALU) and 6 gives bus_oe[5] (temp register). Codes 0 and 7 enable no driver. At most one bit of bus_oe is ever high.
- R2: A step-clear request, which is either the dedicated microcode bit or driver code 7, shows on step_clr and makes the step zero at the next falling edge. Without a request the step advances by one at each falling edge and wraps from 7 to 0.
- R3: The opcode and flags are captured only on the falling edge. A change of instr, flag_c or flag_z after a rising edge leaves every output unchanged until the next falling edge.
- R4: rst is asynchronous and active high. It clears the step and the captured opcode at once, so the outputs show fetch step 0 (bus_oe[2] and mar_ld) while it is held.
- R5: For every opcode, step 0 is pc out plus mar_ld, and step 1 is RAM out plus ir_ld plus pc_inc. For opcode 8'h00 and for any opcode not listed in R6 to R8, step 1 also asserts step_clr.
- R6: Opcode 8'h08 (accumulator load) runs steps 2 to 4 as: pc out with mar_ld; RAM out with mar_ld and pc_inc; RAM out with a_ld and step_clr.
- R7: Opcodes 8'b00010rrr (load immediate into slot rrr) run steps 2 to 6 as: pc out with mar_ld; RAM out with tmp_ld and pc_inc; instruction-register out with mar_ld; temp out with seg_hi and ram_we; then driver code 7 alone, which asserts step_clr with no driver.
- R8: Opcode 8'h20 (call) runs steps 2 to 6 as: pc out with mar_ld; RAM out with tmp_ld and pc_inc; mar_ld alone; pc out with seg_hi and ram_we; temp out with pc_ld and step_clr. Opcode 8'h21 (return) runs steps 2 to 3 as: mar_ld alone; RAM out with seg_hi, pc_ld and step_clr.
- R9: While ctl_off is high, every output is 0 and no step clear happens, so the step keeps advancing and wrapping.
- R10: The flags are part of the 13-bit microcode address {flags, opcode, step}. No word of the table depends on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the sequencer updates on its falling edge |
| rst | input | 1 | Asynchronous active-high reset |
| instr | input | 8 | Current instruction register value |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| ctl_off | input | 1 | Forces all control outputs inactive |
| bus_oe | output | 6 | One-hot bus driver enables (RAM, IR, PC, A, ALU, temp) |
| mar_ld | output | 1 | Memory address register load |
| ir_ld | output | 1 | Instruction register load |
| pc_inc | output | 1 | Program counter increment |
| a_ld | output | 1 | Accumulator load |
| tmp_ld | output | 1 | Temp register load |
| ram_we | output | 1 | RAM write |
| seg_hi | output | 1 | Selects the data half of memory |
| pc_ld | output | 1 | Program counter load (jump) |
| step_clr | output | 1 | Step-clear request active this cycle |

## Verification
A step-clear request and the external disable can fall in the same cycle. The disable must win: the counter advances instead of clearing. The bench provokes this by waiting for a cycle whose word carries a step clear and raising ctl_off after the rising edge and before the falling edge that ends that cycle. After releasing it, the bench checks that the next visible word is the step that follows, not fetch step 0. The random run also lands disables on clear cycles. Every word is compared with a model that predicts opcode and step from the requirements.

// File: rtl/ucode_seq.sv
module ucode_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] instr,
  input  logic       flag_c,
  input  logic       flag_z,
  input  logic       ctl_off,
  output logic [5:0] bus_oe,
  output logic       mar_ld,
  output logic       ir_ld,
  output logic       pc_inc,
  output logic       a_ld,
  output logic       tmp_ld,
  output logic       ram_we,
  output logic       seg_hi,
  output logic       pc_ld,
  output logic       step_clr
);
  localparam int SW = 3;
  localparam int OW = 8;
  localparam int AW = 2 + OW + SW;
  localparam int NDRV = 6;

  // driver codes: 4 = accumulator, 5 = ALU are decoded but unused by this table
  localparam logic [11:0] RO = 12'd1;
  localparam logic [11:0] IO = 12'd2;
  localparam logic [11:0] CO = 12'd3;
  localparam logic [11:0] BO = 12'd6;
  localparam logic [11:0] FR = 12'd7;
  localparam logic [11:0] MI = 12'h008;
  localparam logic [11:0] II = 12'h010;
  localparam logic [11:0] CE = 12'h020;
  localparam logic [11:0] AI = 12'h040;
  localparam logic [11:0] BI = 12'h080;
  localparam logic [11:0] RI = 12'h100;
  localparam logic [11:0] MP = 12'h200;
  localparam logic [11:0] JP = 12'h400;
  localparam logic [11:0] SR = 12'h800;

  localparam logic [OW-1:0] OP_LDA  = 8'h08;
  localparam logic [OW-1:0] OP_CALL = 8'h20;
  localparam logic [OW-1:0] OP_RET  = 8'h21;

  function automatic logic [11:0] ucode(input logic [OW-1:0] op, input logic [SW-1:0] s);
    logic known;
    known = (op == OP_LDA) || (op[7:3] == 5'b00010) || (op == OP_CALL) || (op == OP_RET);
    ucode = '0;
    if (s == 3'd0)
      ucode = CO | MI;
    else if (s == 3'd1)
      ucode = RO | II | CE | (known ? 12'h000 : SR);
    else if (op == OP_LDA)
      case (s)
        3'd2: ucode = CO | MI;
        3'd3: ucode = MI | RO | CE;
        3'd4: ucode = RO | AI | SR;
        default: ucode = '0;
      endcase
    else if (op[7:3] == 5'b00010)
      case (s)
        3'd2: ucode = CO | MI;
        3'd3: ucode = BI | RO | CE;
        3'd4: ucode = IO | MI;
        3'd5: ucode = BO | MP | RI;
        3'd6: ucode = FR;
        default: ucode = '0;
      endcase
    else if (op == OP_CALL)
      case (s)
        3'd2: ucode = CO | MI;
        3'd3: ucode = RO | BI | CE;
        3'd4: ucode = MI;
        3'd5: ucode = MP | CO | RI;
        3'd6: ucode = BO | JP | SR;
        default: ucode = '0;
      endcase
    else if (op == OP_RET)
      case (s)
        3'd2: ucode = MI;
        3'd3: ucode = MP | RO | JP | SR;
        default: ucode = '0;
      endcase
  endfunction

  logic [AW-1:0] ua;
  logic [SW-1:0] step;
  logic [AW-SW-1:0] ua_hi;
  logic [11:0] w;
  logic [2:0] drv;
  logic clr;
  logic flg_unused;

  always_ff @(negedge clk or posedge rst)
    if (rst) begin
      ua_hi <= '0;
      step  <= '0;
    end else begin
      ua_hi <= {flag_c, flag_z, instr};
      step  <= clr ? '0 : step + 1'b1;
    end

  assign ua  = {ua_hi, step};
  assign flg_unused = ^ua[AW-1:AW-2];
  assign w   = ctl_off ? '0 : ucode(ua[SW+OW-1:SW], ua[SW-1:0]);
  assign drv = w[2:0];
  assign clr = w[11] | (drv == 3'd7);

  for (genvar k = 0; k < NDRV; k++) begin : g_oe
    assign bus_oe[k] = (drv == 3'(k + 1));
  end

  assign mar_ld   = w[3];
  assign ir_ld    = w[4];
  assign pc_inc   = w[5];
  assign a_ld     = w[6];
  assign tmp_ld   = w[7];
  assign ram_we   = w[8];
  assign seg_hi   = w[9];
  assign pc_ld    = w[10];
  assign step_clr = clr;
endmodule

module ucode_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       ctl_off,
  input logic [2:0] step,
  input logic       step_clr,
  input logic [5:0] bus_oe,
  input logic       mar_ld,
  input logic       ir_ld,
  input logic       pc_inc,
  input logic       a_ld,
  input logic       tmp_ld,
  input logic       ram_we,
  input logic       seg_hi,
  input logic       pc_ld
);
  assert_one_driver_R1: assert property (@(posedge clk) disable iff (rst) $onehot0(bus_oe));

  assert_step_clear_R2: assert property (@(negedge clk) disable iff (rst)
    step_clr |=> (step == 3'd0));

  assert_step_advance_R2: assert property (@(negedge clk) disable iff (rst)
    !step_clr |=> (step == 3'($past(step) + 3'd1)));

  assert_masked_R9: assert property (@(posedge clk) disable iff (rst)
    ctl_off |-> (bus_oe == 6'd0 && !mar_ld && !ir_ld && !pc_inc && !a_ld && !tmp_ld
                 && !ram_we && !seg_hi && !pc_ld && !step_clr));
endmodule

bind ucode_seq ucode_seq_chk u_chk (
  .clk(clk), .rst(rst), .ctl_off(ctl_off), .step(step), .step_clr(step_clr),
  .bus_oe(bus_oe), .mar_ld(mar_ld), .ir_ld(ir_ld), .pc_inc(pc_inc), .a_ld(a_ld),
  .tmp_ld(tmp_ld), .ram_we(ram_we), .seg_hi(seg_hi), .pc_ld(pc_ld)
);

// File: tb/ucode_seq_tb.sv
module ucode_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] instr = 8'h00;
  logic fc = 1'b0, fz = 1'b0, dis = 1'b0;
  logic [5:0] bus_oe;
  logic mar_ld, ir_ld, pc_inc, a_ld, tmp_ld, ram_we, seg_hi, pc_ld, step_clr;
  logic [14:0] got;
  int n_run = 0, n_fail = 0;
  logic [7:0] m_op = 8'h00;
  logic [2:0] m_step = 3'd0;
  logic [1:0] m_flg = 2'd0;
  logic [14:0] last_w = '0;
  string force_tag = "";
  logic done = 1'b0;

  always #4 clk = ~clk;

  ucode_seq u_dut (
    .clk(clk), .rst(rst), .instr(instr), .flag_c(fc), .flag_z(fz), .ctl_off(dis),
    .bus_oe(bus_oe), .mar_ld(mar_ld), .ir_ld(ir_ld), .pc_inc(pc_inc), .a_ld(a_ld),
    .tmp_ld(tmp_ld), .ram_we(ram_we), .seg_hi(seg_hi), .pc_ld(pc_ld), .step_clr(step_clr)
  );

  assign got = {bus_oe, mar_ld, ir_ld, pc_inc, a_ld, tmp_ld, ram_we, seg_hi, pc_ld, step_clr};

  localparam logic [14:0] D_RAM = 15'h0200, D_IR = 15'h0400, D_PC = 15'h0800,
                          D_T = 15'h4000, MAR = 15'h0100, IRL = 15'h0080, PCI = 15'h0040,
                          AL = 15'h0020, TL = 15'h0010, WE = 15'h0008, SEG = 15'h0004,
                          PCL = 15'h0002, CLR = 15'h0001;

  function automatic logic [14:0] exp_ctl(input logic [7:0] op, input logic [2:0] st, input logic off);
    logic lda, ldi, cal, ret;
    lda = (op == 8'h08); ldi = (op[7:3] == 5'b00010);
    cal = (op == 8'h20); ret = (op == 8'h21);
    exp_ctl = '0;
    if (off) exp_ctl = '0;
    else if (st == 0) exp_ctl = D_PC | MAR;
    else if (st == 1) exp_ctl = D_RAM | IRL | PCI | ((lda | ldi | cal | ret) ? 15'h0 : CLR);
    else if (lda) begin
      if (st == 2) exp_ctl = D_PC | MAR;
      if (st == 3) exp_ctl = D_RAM | MAR | PCI;
      if (st == 4) exp_ctl = D_RAM | AL | CLR;
    end else if (ldi) begin
      if (st == 2) exp_ctl = D_PC | MAR;
      if (st == 3) exp_ctl = D_RAM | TL | PCI;
      if (st == 4) exp_ctl = D_IR | MAR;
      if (st == 5) exp_ctl = D_T | SEG | WE;
      if (st == 6) exp_ctl = CLR;
    end else if (cal) begin
      if (st == 2) exp_ctl = D_PC | MAR;
      if (st == 3) exp_ctl = D_RAM | TL | PCI;
      if (st == 4) exp_ctl = MAR;
      if (st == 5) exp_ctl = D_PC | SEG | WE;
      if (st == 6) exp_ctl = D_T | PCL | CLR;
    end else if (ret) begin
      if (st == 2) exp_ctl = MAR;
      if (st == 3) exp_ctl = D_RAM | SEG | PCL | CLR;
    end
  endfunction

  function automatic string tag_of(input logic [7:0] op, input logic [2:0] st, input logic off);
    if (off) return "R9";
    if (st < 2) return "R5";
    if (op == 8'h08) return "R6";
    if (op[7:3] == 5'b00010) return "R7";
    if (op == 8'h20 || op == 8'h21) return "R8";
    return "R5";
  endfunction

  function automatic logic [7:0] next_op();
    int r;
    r = $urandom % 8;
    case (r)
      0: return 8'h00;
      1: return 8'h08;
      2: return {5'b00010, 3'($urandom % 8)};
      3: return 8'h20;
      4: return 8'h21;
      default: return 8'($urandom);
    endcase
  endfunction

  task automatic check(input string tag, input logic [14:0] act, input logic [14:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // called at posedge+1; drives, checks R3, then follows the falling edge
  task automatic cyc(input logic [7:0] nin, input logic nfc, input logic nfz, input logic ndis);
    logic [14:0] w;
    instr = nin; fc = nfc; fz = nfz; dis = ndis;
    #1;
    check("R3", got, exp_ctl(m_op, m_step, dis));
    @(negedge clk);
    if (!rst) begin
      w = exp_ctl(m_op, m_step, dis);
      m_op = instr;
      m_flg = {fc, fz};
      m_step = w[0] ? 3'd0 : m_step + 3'd1;
    end
    #2;
    w = exp_ctl(m_op, m_step, dis);
    check(force_tag != "" ? force_tag : tag_of(m_op, m_step, dis), got, w);
    if (m_flg != 2'd0) check("R10", got, w);
    if (w[0]) check("R2", {14'd0, step_clr}, 15'd1);
    n_run++;
    if (!$onehot0(bus_oe)) begin
      n_fail++;
      $display("FAIL R1 act=%b exp=onehot0", bus_oe);
    end
    last_w = w;
    @(posedge clk); #1;
  endtask

  initial begin
    logic [7:0] ir;
    int dis_left;
    void'($urandom(32'h5EED));
    ir = 8'h00;
    dis_left = 0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    check("R4", got, D_PC | MAR);
    rst = 1'b0;

    // R2: wrap under disable, then resume
    for (int i = 0; i < 11; i++) cyc(ir, 1'b0, 1'b0, 1'b1);
    force_tag = "R2";
    cyc(ir, 1'b0, 1'b0, 1'b0);
    force_tag = "";

    // R9 with R2: disable lands on a step-clear cycle
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 20 && !(last_w[0]); i++) begin
        if (last_w[7]) ir = next_op();
        cyc(ir, 1'b0, 1'b1, 1'b0);
      end
      force_tag = "R9";
      cyc(ir, 1'b0, 1'b0, 1'b1);
      force_tag = "R2";
      cyc(ir, 1'b0, 1'b0, 1'b0);
      force_tag = "";
    end

    // R4: asynchronous reset mid-run
    ir = 8'h20;
    for (int i = 0; i < 4; i++) cyc(ir, 1'b1, 1'b1, 1'b0);
    rst = 1'b1;
    #1;
    check("R4", got, D_PC | MAR);
    @(posedge clk); #1;
    rst = 1'b0;
    m_op = 8'h00; m_step = 3'd0; m_flg = 2'd0; last_w = D_PC | MAR;
    ir = 8'h00;

    // random program stream
    for (int i = 0; i < 4000; i++) begin
      logic nd;
      if (last_w[7]) ir = next_op();
      nd = 1'b0;
      if (dis_left > 0) begin
        dis_left--; nd = 1'b1;
      end else if ($urandom % 40 == 0) begin
        dis_left = int'($urandom % 12);
        nd = 1'b1;
      end
      cyc(ir, 1'($urandom), 1'($urandom), nd);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule